// File: doc/BRIEF.md
# Six-Source Two-Level Interrupt Controller

This block sits between six interrupt-flag producers and a CPU core. It takes two external-interrupt flags, the flags of three timers and the two serial-port done flags. It gates them through an 8-bit enable register that has a global enable, and ranks them through a 6-bit priority register that gives each source one of two levels. It then presents at most one vector request to the core. The request carries the winning source index, its level and its vector address.

When the core takes a vector, the controller marks that level as in service. A low-level handler can then be preempted only by a high-level request, and a high-level handler cannot be preempted at all. A return-from-interrupt strobe clears the highest level that is in service. On each acknowledge the block emits a one-cycle clear strobe toward the flag producers. This strobe goes only to sources whose flags hardware is allowed to clear: timer 0, timer 1, and the external inputs while they are in edge mode. A separate wake output tells idle-mode logic that an enabled request exists.

Top module: `irq_ctrl6`

## Requirements
- R1: The enable register resets to 0x00. A write stores bit 7 (global enable), bit 5 (timer 2), bit 4 (serial), bit 3 (timer 1), bit 2 (external 1), bit 1 (timer 0) and bit 0 (external 0). Bit 6 is reserved: it always reads 0, whatever is written to it.
- R2: While enable bit 7 is 0, `irq_req` and `wake` stay 0 whatever the flags and the individual enables are.
- R3: A source whose individual enable bit is 0 is never presented and does not drive `wake`.
- R4: The priority register resets to 0 and uses the same bit order as enable bits 5..0. A 1 selects the high level.
- R5: Among the presentable requests, a high-level one wins over a low-level one. Within a level the lowest index wins. The indices are external 0=0, timer 0=1, external 1=2, timer 1=3, serial=4 and timer 2=5, and `irq_src` carries the winner's index.
- R6: `irq_vec` equals 0x03 + 8 × `irq_src`, which gives 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B.
- R7: The timer 2 request is its overflow flag OR its external flag. The serial request is its transmit-done flag OR its receive-done flag.
- R8: A cycle with `cpu_ack` high while `irq_req` is high sets `in_service[irq_level]` at the next edge. While `in_service[1]` is set, no request is presented. While only `in_service[0]` is set, only high-level requests are presented.
- R9: `cpu_reti` clears `in_service[1]` if that bit is set, and otherwise clears `in_service[0]`. When `cpu_reti` and an acknowledge occur in the same cycle, the clear is applied first and the acknowledge's set second.
- R10: On an acknowledge, `flag_clr` pulses for that cycle with the winner's bit set, but only when the winner is timer 0, timer 1, or an external source whose edge-mode input is 1. The strobe never pulses for serial, for timer 2, or for an external source in level mode.
- R11: `wake` is 1 exactly when some source is requesting, is individually enabled and is globally enabled, regardless of the in-service state.
- R12: After reset, `irq_req` is 0 and `in_service` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_flag | input | 1 | External 0 request flag |
| ext0_edge | input | 1 | External 0 is edge mode (1) or level mode (0) |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External 1 request flag |
| ext1_edge | input | 1 | External 1 is edge mode (1) or level mode (0) |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_tx_flag | input | 1 | Serial transmit-done flag |
| ser_rx_flag | input | 1 | Serial receive-done flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external-event flag |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| pri_we | input | 1 | Priority register write strobe |
| pri_wdata | input | 6 | Priority register write data |
| cpu_ack | input | 1 | Core takes the presented vector |
| cpu_reti | input | 1 | Core returns from a handler |
| en_q | output | 8 | Enable register contents |
| pri_q | output | 6 | Priority register contents |
| irq_req | output | 1 | A vector request is presented |
| irq_src | output | 3 | Winning source index |
| irq_level | output | 1 | Winning source level (1 = high) |
| irq_vec | output | 8 | Winning vector address |
| in_service | output | 2 | In-service bit per level |
| flag_clr | output | 6 | One-cycle hardware clear per source |
| wake | output | 1 | Enabled request exists (idle exit) |

## Verification
The request, source, level, vector, wake and clear-strobe outputs are combinational functions of the current flags and the registered state. They are therefore due in the same cycle as the stimulus. The bench samples them one nanosecond after the edge at which its inputs were applied, and again at the falling edge. Register writes and the in-service set and clear take effect at the next rising edge, so their results are due one cycle after the strobe. The reference model in the bench updates its own state at that same edge, and the next comparison picks up the new values. Directed sequences cover preemption, blocking at equal level, simultaneous return and acknowledge, and the reserved bit. A long random phase then compares every output on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC     = 6;
    localparam int IDXW     = $clog2(NSRC);
    localparam int ENW      = 8;
    localparam int NLVL     = 2;
    localparam int GLB_BIT  = 7;
    localparam int RSV_BIT  = 6;
    localparam int VECW     = 8;
    localparam logic [VECW-1:0] VEC_BASE = 8'h03;
    localparam logic [VECW-1:0] VEC_STEP = 8'h08;

    typedef enum logic [IDXW-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;

    typedef struct packed {
        logic            valid;
        logic            level;
        logic [IDXW-1:0] idx;
    } win_t;

    // lowest set index wins; loop runs from high to low so the last hit is the lowest
    function automatic logic [IDXW-1:0] lowest_set(input logic [NSRC-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        return VEC_BASE + VECW'(idx) * VEC_STEP;
    endfunction

    // sources whose flags hardware may clear on acknowledge
    function automatic logic hw_clearable(input logic [IDXW-1:0] idx,
                                          input logic e0_edge, input logic e1_edge);
        case (idx)
            SRC_TMR0, SRC_TMR1: return 1'b1;
            SRC_EXT0:           return e0_edge;
            SRC_EXT1:           return e1_edge;
            default:            return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en_we,
    input  logic [ENW-1:0]  en_wdata,
    input  logic            pri_we,
    input  logic [NSRC-1:0] pri_wdata,
    output logic [ENW-1:0]  en_q,
    output logic [NSRC-1:0] pri_q
);
    localparam logic [ENW-1:0] EN_MASK = ~(ENW'(1) << RSV_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pri_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata & EN_MASK;
            if (pri_we) pri_q <= pri_wdata;
        end
    end

    a_r1_en_write: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (en_q[NSRC-1:0] == $past(en_wdata[NSRC-1:0])) && (en_q[GLB_BIT] == $past(en_wdata[GLB_BIT])));
    a_r1_en_hold: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> $stable(en_q));
    a_r4_pri_write: assert property (@(posedge clk) disable iff (rst)
        pri_we |=> pri_q == $past(pri_wdata));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raw,
    input  logic [ENW-1:0]  en_q,
    input  logic [NSRC-1:0] pri_q,
    input  logic [NLVL-1:0] ins,
    output win_t            win,
    output logic            wake
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] hi_pend;
    logic [NSRC-1:0] lo_pend;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign pend[i]    = raw[i] & en_q[i] & en_q[GLB_BIT];
        assign hi_pend[i] = pend[i] & pri_q[i];
        assign lo_pend[i] = pend[i] & ~pri_q[i];
    end

    always_comb begin
        win = '0;
        if (!ins[1] && |hi_pend) begin
            win.valid = 1'b1;
            win.level = 1'b1;
            win.idx   = lowest_set(hi_pend);
        end else if (ins == '0 && |lo_pend) begin
            win.valid = 1'b1;
            win.level = 1'b0;
            win.idx   = lowest_set(lo_pend);
        end
    end

    assign wake = |pend;

    a_r2_global_off: assert property (@(posedge clk) disable iff (rst)
        !en_q[GLB_BIT] |-> (!win.valid && !wake));
    a_r8_high_busy: assert property (@(posedge clk) disable iff (rst)
        ins[1] |-> !win.valid);
    a_r8_low_busy: assert property (@(posedge clk) disable iff (rst)
        (ins[0] && win.valid) |-> win.level);
    a_r3_winner_enabled: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (en_q[win.idx] && raw[win.idx]));
endmodule

// File: rtl/irqc_inservice.sv
module irqc_inservice
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            take_level,
    input  logic            reti,
    output logic [NLVL-1:0] ins
);
    logic [NLVL-1:0] after_reti;

    always_comb begin
        after_reti = ins;
        if (reti) begin
            if (ins[1]) after_reti[1] = 1'b0;
            else        after_reti[0] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins <= '0;
        end else begin
            ins <= after_reti;
            if (take) ins[take_level] <= 1'b1;
        end
    end

    a_r8_take_marks: assert property (@(posedge clk) disable iff (rst)
        take |=> ins[$past(take_level)]);
    a_r9_reti_top: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && ins[1]) |=> (!ins[1] && ins[0] == $past(ins[0])));
    a_r9_reti_low: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && ins == 2'b01) |=> ins == 2'b00);
endmodule

// File: rtl/irq_ctrl6.sv
module irq_ctrl6
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ext0_flag,
    input  logic        ext0_edge,
    input  logic        tmr0_flag,
    input  logic        ext1_flag,
    input  logic        ext1_edge,
    input  logic        tmr1_flag,
    input  logic        ser_tx_flag,
    input  logic        ser_rx_flag,
    input  logic        tmr2_ovf_flag,
    input  logic        tmr2_ext_flag,
    input  logic        en_we,
    input  logic [7:0]  en_wdata,
    input  logic        pri_we,
    input  logic [5:0]  pri_wdata,
    input  logic        cpu_ack,
    input  logic        cpu_reti,
    output logic [7:0]  en_q,
    output logic [5:0]  pri_q,
    output logic        irq_req,
    output logic [2:0]  irq_src,
    output logic        irq_level,
    output logic [7:0]  irq_vec,
    output logic [1:0]  in_service,
    output logic [5:0]  flag_clr,
    output logic        wake
);
    logic [NSRC-1:0] raw;
    win_t            win;
    logic            take;

    always_comb begin
        raw           = '0;
        raw[SRC_EXT0] = ext0_flag;
        raw[SRC_TMR0] = tmr0_flag;
        raw[SRC_EXT1] = ext1_flag;
        raw[SRC_TMR1] = tmr1_flag;
        raw[SRC_SER]  = ser_tx_flag | ser_rx_flag;
        raw[SRC_TMR2] = tmr2_ovf_flag | tmr2_ext_flag;
    end

    irqc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .pri_we    (pri_we),
        .pri_wdata (pri_wdata),
        .en_q      (en_q),
        .pri_q     (pri_q)
    );

    irqc_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw),
        .en_q  (en_q),
        .pri_q (pri_q),
        .ins   (in_service),
        .win   (win),
        .wake  (wake)
    );

    assign take = cpu_ack & win.valid;

    irqc_inservice u_ins (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .take_level (win.level),
        .reti       (cpu_reti),
        .ins        (in_service)
    );

    assign irq_req   = win.valid;
    assign irq_src   = win.idx;
    assign irq_level = win.level;
    assign irq_vec   = vec_of(win.idx);

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        assign flag_clr[i] = take && (win.idx == IDXW'(i)) &&
                             hw_clearable(IDXW'(i), ext0_edge, ext1_edge);
    end

    a_r11_req_wakes: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> wake);
    a_r10_clr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_clr));
    a_r10_clr_needs_ack: assert property (@(posedge clk) disable iff (rst)
        (|flag_clr) |-> (cpu_ack && irq_req));
    a_r10_never_t2_ser: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && irq_req && irq_src >= 3'd4) |-> flag_clr == 6'd0);
    a_r12_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (in_service == 2'b00 && !irq_req));
endmodule

// File: tb/irq_ctrl6_tb.sv
module irq_ctrl6_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext0_flag = 0, ext0_edge = 0, tmr0_flag = 0, ext1_flag = 0, ext1_edge = 0, tmr1_flag = 0;
    logic ser_tx_flag = 0, ser_rx_flag = 0, tmr2_ovf_flag = 0, tmr2_ext_flag = 0;
    logic en_we = 0, pri_we = 0, cpu_ack = 0, cpu_reti = 0;
    logic [7:0] en_wdata = 0;
    logic [5:0] pri_wdata = 0;
    logic [7:0] en_q;
    logic [5:0] pri_q;
    logic irq_req, irq_level, wake;
    logic [2:0] irq_src;
    logic [7:0] irq_vec;
    logic [1:0] in_service;
    logic [5:0] flag_clr;

    int checks = 0;
    int fails = 0;
    bit compare_on = 0;
    bit done = 0;

    // reference model state
    int m_en = 0, m_pri = 0, m_ins = 0;
    int e_req, e_idx, e_lvl, e_wake, e_clr;

    always #2.5 clk = ~clk;

    irq_ctrl6 u_dut (
        .clk(clk), .rst(rst),
        .ext0_flag(ext0_flag), .ext0_edge(ext0_edge), .tmr0_flag(tmr0_flag),
        .ext1_flag(ext1_flag), .ext1_edge(ext1_edge), .tmr1_flag(tmr1_flag),
        .ser_tx_flag(ser_tx_flag), .ser_rx_flag(ser_rx_flag),
        .tmr2_ovf_flag(tmr2_ovf_flag), .tmr2_ext_flag(tmr2_ext_flag),
        .en_we(en_we), .en_wdata(en_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
        .en_q(en_q), .pri_q(pri_q), .irq_req(irq_req), .irq_src(irq_src),
        .irq_level(irq_level), .irq_vec(irq_vec), .in_service(in_service),
        .flag_clr(flag_clr), .wake(wake)
    );

    task automatic expect_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected outputs from inputs and model state
    task automatic predict();
        int raw, pend, hi, lo;
        raw = 0;
        if (ext0_flag) raw += 1;
        if (tmr0_flag) raw += 2;
        if (ext1_flag) raw += 4;
        if (tmr1_flag) raw += 8;
        if (ser_tx_flag || ser_rx_flag) raw += 16;
        if (tmr2_ovf_flag || tmr2_ext_flag) raw += 32;
        pend = ((m_en & 128) != 0) ? (raw & m_en & 63) : 0;
        hi = pend & m_pri;
        lo = pend & ~m_pri & 63;
        e_req = 0; e_idx = 0; e_lvl = 0;
        if ((m_ins & 2) == 0 && hi != 0) begin
            e_req = 1; e_lvl = 1;
            for (int i = 5; i >= 0; i--) if (hi[i]) e_idx = i;
        end else if (m_ins == 0 && lo != 0) begin
            e_req = 1; e_lvl = 0;
            for (int i = 5; i >= 0; i--) if (lo[i]) e_idx = i;
        end
        e_wake = (pend != 0) ? 1 : 0;
        e_clr = 0;
        if (cpu_ack && e_req == 1) begin
            if (e_idx == 1 || e_idx == 3 || (e_idx == 0 && ext0_edge) || (e_idx == 2 && ext1_edge))
                e_clr = 1 << e_idx;
        end
    endtask

    task automatic compare_all();
        predict();
        expect_eq("R1 enable reg", int'(en_q), m_en);
        expect_eq("R4 priority reg", int'(pri_q), m_pri);
        expect_eq("R8 in_service", int'(in_service), m_ins);
        expect_eq("R5 irq_req", int'(irq_req), e_req);
        expect_eq("R11 wake", int'(wake), e_wake);
        expect_eq("R10 flag_clr", int'(flag_clr), e_clr);
        if (e_req == 1) begin
            expect_eq("R5 irq_src", int'(irq_src), e_idx);
            expect_eq("R8 irq_level", int'(irq_level), e_lvl);
            expect_eq("R6 irq_vec", int'(irq_vec), 3 + 8 * e_idx);
        end
    endtask

    task automatic model_edge();
        int nins;
        predict();
        if (rst) begin
            m_en = 0; m_pri = 0; m_ins = 0;
        end else begin
            nins = m_ins;
            if (cpu_reti) begin
                if ((m_ins & 2) != 0) nins = nins & 1;
                else nins = nins & 2;
            end
            if (cpu_ack && e_req == 1) nins = nins | (1 << e_lvl);
            m_ins = nins;
            if (en_we) m_en = int'(en_wdata) & 8'hBF;
            if (pri_we) m_pri = int'(pri_wdata);
        end
    endtask

    // one cycle: inputs already set; compare at negedge, model at posedge, return after edge
    task automatic step();
        @(negedge clk);
        if (compare_on) compare_all();
        @(posedge clk);
        model_edge();
        #1;
        if (compare_on) compare_all();
    endtask

    task automatic clear_strobes();
        en_we = 0; pri_we = 0; cpu_ack = 0; cpu_reti = 0;
    endtask

    task automatic clear_flags();
        ext0_flag = 0; tmr0_flag = 0; ext1_flag = 0; tmr1_flag = 0;
        ser_tx_flag = 0; ser_rx_flag = 0; tmr2_ovf_flag = 0; tmr2_ext_flag = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1;
        step();
        step();
        compare_on = 1;
        rst = 0;
        step();
        // R12 reset state
        expect_eq("R12 irq_req after reset", int'(irq_req), 0);
        expect_eq("R12 in_service after reset", int'(in_service), 0);
        expect_eq("R1 enable reset", int'(en_q), 0);
        expect_eq("R4 priority reset", int'(pri_q), 0);

        // R2: flags but nothing enabled
        ext0_flag = 1; tmr2_ovf_flag = 1;
        step();
        expect_eq("R2 no req when disabled", int'(irq_req), 0);
        expect_eq("R2 no wake when disabled", int'(wake), 0);

        // R1: all ones; reserved bit reads 0
        en_wdata = 8'hFF; en_we = 1; step(); clear_strobes();
        expect_eq("R1 reserved bit6 reads 0", int'(en_q), 8'hBF);

        // R5/R6: all flags, low level, ext0 wins
        clear_flags();
        ext0_flag = 1; tmr0_flag = 1; ext1_flag = 1; tmr1_flag = 1; ser_rx_flag = 1; tmr2_ext_flag = 1;
        step();
        expect_eq("R5 ext0 wins tie", int'(irq_src), 0);
        expect_eq("R6 vector 0x03", int'(irq_vec), 8'h03);

        // R4/R5: timer1 high level wins over ext0
        pri_wdata = 6'b001000; pri_we = 1; step(); clear_strobes();
        expect_eq("R5 high level wins", int'(irq_src), 3);
        expect_eq("R6 vector 0x1B", int'(irq_vec), 8'h1B);

        // R10: ack timer1 -> clear strobe; R8 high in service
        cpu_ack = 1; step();
        cpu_ack = 0; tmr1_flag = 0;
        step();
        expect_eq("R8 high in service", int'(in_service), 2'b10);
        expect_eq("R8 nothing while high busy", int'(irq_req), 0);
        expect_eq("R11 wake while busy", int'(wake), 1);
        cpu_reti = 1; step(); clear_strobes();
        expect_eq("R9 reti clears high", int'(in_service), 0);

        // R10: ext0 level mode ack -> no clear; low in service
        ext0_edge = 0;
        cpu_ack = 1;
        @(negedge clk);
        expect_eq("R10 level ext no clear", int'(flag_clr), 0);
        @(posedge clk); model_edge(); #1;
        clear_strobes();
        expect_eq("R8 low in service", int'(in_service), 2'b01);
        expect_eq("R8 low blocks low", int'(irq_req), 0);

        // R7/R8: timer2 via external flag at high level preempts
        clear_flags();
        tmr2_ext_flag = 1; pri_wdata = 6'b100000; pri_we = 1; step(); clear_strobes();
        expect_eq("R7 t2 ext flag requests", int'(irq_src), 5);
        expect_eq("R6 vector 0x2B", int'(irq_vec), 8'h2B);
        cpu_ack = 1;
        @(negedge clk);
        expect_eq("R10 t2 never cleared", int'(flag_clr), 0);
        @(posedge clk); model_edge(); #1;
        clear_strobes();
        expect_eq("R8 nested levels", int'(in_service), 2'b11);
        cpu_reti = 1; step();
        expect_eq("R9 reti clears top first", int'(in_service), 2'b01);
        step(); clear_strobes();
        expect_eq("R9 second reti clears low", int'(in_service), 2'b00);

        // R9: reti and ack together
        clear_flags(); ser_tx_flag = 1; pri_wdata = 0; pri_we = 1; step(); clear_strobes();
        expect_eq("R7 serial via tx", int'(irq_vec), 8'h23);
        cpu_ack = 1; step(); clear_strobes();
        pri_wdata = 6'b010000; pri_we = 1; step(); clear_strobes();
        cpu_ack = 1; cpu_reti = 1; step(); clear_strobes();
        expect_eq("R9 reti then ack", int'(in_service), 2'b10);
        cpu_reti = 1; step(); clear_strobes();

        // R3: individual enable off
        clear_flags(); tmr0_flag = 1;
        en_wdata = 8'b1000_0001; en_we = 1; step(); clear_strobes();
        expect_eq("R3 disabled source ignored", int'(irq_req), 0);
        expect_eq("R3 disabled source no wake", int'(wake), 0);

        // R10: edge-mode ext1 cleared
        ext1_edge = 1; ext1_flag = 1; en_wdata = 8'h84; en_we = 1; step(); clear_strobes();
        cpu_ack = 1;
        @(negedge clk);
        expect_eq("R10 edge ext1 cleared", int'(flag_clr), 6'b000100);
        @(posedge clk); model_edge(); #1;
        clear_strobes(); cpu_reti = 1; step(); clear_strobes();

        // R2: global off again
        en_wdata = 8'h3F; en_we = 1; step(); clear_strobes();
        expect_eq("R2 global off blocks", int'(irq_req), 0);

        // random phase, model compared every cycle
        for (int n = 0; n < 3000; n++) begin
            ext0_flag = 1'($urandom); tmr0_flag = 1'($urandom); ext1_flag = 1'($urandom);
            tmr1_flag = 1'($urandom); ser_tx_flag = 1'($urandom % 4 == 0);
            ser_rx_flag = 1'($urandom % 4 == 0); tmr2_ovf_flag = 1'($urandom % 3 == 0);
            tmr2_ext_flag = 1'($urandom % 3 == 0);
            ext0_edge = 1'($urandom); ext1_edge = 1'($urandom);
            en_we = 1'($urandom % 8 == 0); en_wdata = 8'($urandom) | 8'h80;
            pri_we = 1'($urandom % 8 == 0); pri_wdata = 6'($urandom);
            cpu_ack = 1'($urandom % 3 == 0); cpu_reti = 1'($urandom % 4 == 0);
            step();
        end
        clear_strobes();
        finish_run();
    end
endmodule